// File: doc/BRIEF.md
# Byte ALU with Status Flag Update

This block is the arithmetic and logic stage of a small 8-bit RISC core. Each request carries two byte operands, a 5-bit operation code and the current 8-bit status word. One cycle later the block returns the byte result and a revised status word. Every operation class rewrites only the flags it owns and passes all other status bits through unchanged.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. There is one register stage. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output stays frozen and no new request is taken. A consumer that holds `out_ready` high gets one result per cycle.

The status word has a fixed bit layout, from bit 7 down to bit 0:

| Bit | 7 | 6 | 5 | 4 | 3 | 2 | 1 | 0 |
|-----|---|---|---|---|---|---|---|---|
| Flag | I (global enable) | T (bit store) | H (half carry) | S (sign) | V (overflow) | N (negative) | Z (zero) | C (carry) |

Top module: `alu8_core`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. `in_ready` equals `!out_valid || out_ready`. A request accepted on one edge shows up with `out_valid` high after that edge.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_result` and `out_sreg` hold their values and `out_valid` stays 1.
- R3: Status bits 7 (I) and 6 (T) are always copied from the input. For every operation that writes flags, S (bit 4) equals N (bit 2) XOR V (bit 3).
- R4: Code 0 (add) returns a+b. Code 1 (add with carry) returns a+b+C. Both set C to the carry out of bit 7 and H to the carry out of bit 3. V is two's-complement overflow, N is result bit 7, and Z is set when the result is zero.
- R5: Code 2 (subtract) returns a−b. Code 3 (subtract with carry) returns a−b−C. C and H are the borrows out of bit 7 and bit 3, and V is signed overflow. Code 2 sets Z when the result is zero. Code 3 sets Z only when the result is zero and Z was already 1.
- R6: Codes 4 (AND), 5 (OR) and 6 (XOR) combine a with b. They write Z and N, clear V, and leave C and H unchanged. Setting bits with mask K is OR with K. Clearing bits is AND with 0xFF−K.
- R7: Code 7 returns 0xFF−a. It sets C, clears V, writes Z and N, and keeps H. Code 8 returns 0x00−a, with flags as for subtracting a from zero.
- R8: Code 9 returns a+1 and code 10 returns a−1. V is set for an increment result of 0x80 and for a decrement result of 0x7F. Both write Z and N and keep C and H.
- R9: Code 11 is a logical left shift and code 12 a logical right shift. In each, a 0 enters the vacated end. Code 15 is an arithmetic right shift that keeps bit 7. All three set C to the bit shifted out, set V to N XOR C, and keep H.
- R10: Code 13 rotates left through carry: old C enters bit 0 and bit 7 becomes C. Code 14 rotates right through carry: old C enters bit 7 and bit 0 becomes C. V is N XOR C and H is kept.
- R11: Code 16 exchanges bits 7..4 with bits 3..0 and leaves the whole status word unchanged.
- R12: Codes 17 to 31 return a unchanged and leave the status word unchanged. Operand b has no effect on codes 7 to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The block can take a request this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | 8 | First operand (destination operand) |
| in_b | input | 8 | Second operand |
| in_sreg | input | 8 | Incoming status word |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_result | output | 8 | Byte result |
| out_sreg | output | 8 | Revised status word |

## Verification
Two things can happen on the same edge: the output register hands a result to the consumer, and it loads the next request. Both the result and the status word come from that register, so this is the case to cover. The bench causes it by holding `in_valid` high while `out_ready` varies at random. A new request is then accepted exactly on edges where the previous result is also drained. Each drained result is compared, in order, against an expected value that a bench model computed when the request was accepted. Separate checks confirm that a stalled output does not change.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int OPW = 5;

  // status word bit positions
  localparam int SB_C = 0;
  localparam int SB_Z = 1;
  localparam int SB_N = 2;
  localparam int SB_V = 3;
  localparam int SB_S = 4;
  localparam int SB_H = 5;
  localparam int SB_T = 6;
  localparam int SB_I = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,  OP_SUBC = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_INV  = 5'd7,
    OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_SHL  = 5'd11,
    OP_SHR  = 5'd12, OP_RCL  = 5'd13, OP_RCR  = 5'd14, OP_SAR  = 5'd15,
    OP_NSW  = 5'd16
  } alu_op_e;

  localparam logic [7:0] M_ARITH = 8'b0011_1111; // H S V N Z C
  localparam logic [7:0] M_LOGIC = 8'b0001_1110; // S V N Z
  localparam logic [7:0] M_LOGC  = 8'b0001_1111; // S V N Z C
  localparam logic [7:0] M_NONE  = 8'b0000_0000;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  input  logic           zin,
  output logic [W-1:0]   res,
  output logic           fh,
  output logic           fv,
  output logic           fn,
  output logic           fz,
  output logic           fc
);
  localparam int HB = W / 2;

  logic [W-1:0]  x, y;
  logic          ci, sub;
  logic [W:0]    full;
  logic [HB:0]   nib;

  always_comb begin
    x = a; y = b; ci = 1'b0; sub = 1'b0;
    case (op)
      OP_ADDC: ci = cin;
      OP_SUB:  sub = 1'b1;
      OP_SUBC: begin sub = 1'b1; ci = cin; end
      OP_NEG:  begin sub = 1'b1; x = '0; y = a; end
      OP_INC:  y = W'(1);
      OP_DEC:  begin sub = 1'b1; y = W'(1); end
      default: ;
    endcase
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - (W+1)'(ci);
      nib  = {1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]} - (HB+1)'(ci);
    end else begin
      full = {1'b0, x} + {1'b0, y} + (W+1)'(ci);
      nib  = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + (HB+1)'(ci);
    end
    res = full[W-1:0];
    fc  = full[W];
    fh  = nib[HB];
    fn  = res[W-1];
    if (sub) fv = (x[W-1] & ~y[W-1] & ~res[W-1]) | (~x[W-1] & y[W-1] & res[W-1]);
    else     fv = (x[W-1] & y[W-1] & ~res[W-1]) | (~x[W-1] & ~y[W-1] & res[W-1]);
    fz  = (res == '0);
    if (op == OP_SUBC) fz = fz & zin;
  end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           fn,
  output logic           fz
);
  localparam int HB = W / 2;

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_INV:  res = ~a;
      OP_NSW:  res = {a[HB-1:0], a[W-1:HB]};
      default: res = a;
    endcase
    fn = res[W-1];
    fz = (res == '0);
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           fv,
  output logic           fn,
  output logic           fz,
  output logic           fc
);
  always_comb begin
    case (op)
      OP_SHL:  begin res = {a[W-2:0], 1'b0};     fc = a[W-1]; end
      OP_RCL:  begin res = {a[W-2:0], cin};      fc = a[W-1]; end
      OP_SHR:  begin res = {1'b0, a[W-1:1]};     fc = a[0];   end
      OP_RCR:  begin res = {cin, a[W-1:1]};      fc = a[0];   end
      OP_SAR:  begin res = {a[W-1], a[W-1:1]};   fc = a[0];   end
      default: begin res = a;                    fc = cin;    end
    endcase
    fn = res[W-1];
    fz = (res == '0);
    fv = fn ^ fc;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  input  logic [7:0]     in_sreg,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_result,
  output logic [7:0]     out_sreg
);
  localparam int HB = W / 2;

  logic [W-1:0] as_res, bw_res, sh_res, nx_res;
  logic as_h, as_v, as_n, as_z, as_c;
  logic bw_n, bw_z;
  logic sh_v, sh_n, sh_z, sh_c;
  logic [7:0] mask, nf, nx_sreg;
  logic fh, fv, fn, fz, fc;
  logic take;

  alu8_addsub #(.W(W)) u_addsub (
    .op(in_op), .a(in_a), .b(in_b), .cin(in_sreg[SB_C]), .zin(in_sreg[SB_Z]),
    .res(as_res), .fh(as_h), .fv(as_v), .fn(as_n), .fz(as_z), .fc(as_c));

  alu8_bitwise #(.W(W)) u_bitwise (
    .op(in_op), .a(in_a), .b(in_b), .res(bw_res), .fn(bw_n), .fz(bw_z));

  alu8_shifter #(.W(W)) u_shifter (
    .op(in_op), .a(in_a), .cin(in_sreg[SB_C]),
    .res(sh_res), .fv(sh_v), .fn(sh_n), .fz(sh_z), .fc(sh_c));

  always_comb begin
    nx_res = in_a; mask = M_NONE;
    fh = 1'b0; fv = 1'b0; fn = 1'b0; fz = 1'b0; fc = 1'b0;
    case (in_op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEG: begin
        nx_res = as_res; mask = M_ARITH;
        fh = as_h; fv = as_v; fn = as_n; fz = as_z; fc = as_c;
      end
      OP_INC, OP_DEC: begin
        nx_res = as_res; mask = M_LOGIC;
        fv = as_v; fn = as_n; fz = as_z;
      end
      OP_AND, OP_OR, OP_XOR: begin
        nx_res = bw_res; mask = M_LOGIC;
        fn = bw_n; fz = bw_z;
      end
      OP_INV: begin
        nx_res = bw_res; mask = M_LOGC;
        fn = bw_n; fz = bw_z; fc = 1'b1;
      end
      OP_NSW: nx_res = bw_res;
      OP_SHL, OP_SHR, OP_RCL, OP_RCR, OP_SAR: begin
        nx_res = sh_res; mask = M_LOGC;
        fv = sh_v; fn = sh_n; fz = sh_z; fc = sh_c;
      end
      default: ;
    endcase
    nf = {2'b00, fh, fn ^ fv, fv, fn, fz, fc};
    nx_sreg = (in_sreg & ~mask) | (nf & mask);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_sreg   <= '0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_result <= nx_res;
        out_sreg   <= nx_sreg;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  // R1: an accepted request produces a result on the next cycle
  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R2: a stalled result does not move
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_sreg));

  // R3: I and T pass through
  a_r3_it_pass: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_sreg[7:6] == $past(in_sreg[7:6]));

  // R3: sign flag consistency for flag-writing codes
  a_r3_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_op <= OP_SAR) |=> out_sreg[SB_S] == (out_sreg[SB_N] ^ out_sreg[SB_V]));

  // R8: increment and decrement keep C and H
  a_r8_keep_ch: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_op == OP_INC || in_op == OP_DEC) |=>
      out_sreg[SB_C] == $past(in_sreg[SB_C]) && out_sreg[SB_H] == $past(in_sreg[SB_H]));

  // R11: nibble swap leaves the status word alone
  a_r11_swap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == OP_NSW |=>
      out_sreg == $past(in_sreg) && out_result == {$past(in_a[HB-1:0]), $past(in_a[W-1:HB])});
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [4:0] in_op = '0;
  logic [7:0] in_a = '0, in_b = '0, in_sreg = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_result, out_sreg;

  int checks = 0;
  int failures = 0;
  bit force_ready = 1'b0;
  bit held = 1'b0;
  logic [15:0] held_val;
  logic [15:0] exp_q[$];
  logic [4:0]  op_q[$];

  always #10 clk = ~clk;

  alu8_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_sreg(in_sreg),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_sreg(out_sreg));

  function automatic string tag(input logic [4:0] op);
    case (op)
      0, 1:       return "R4";
      2, 3:       return "R5";
      4, 5, 6:    return "R6";
      7, 8:       return "R7";
      9, 10:      return "R8";
      11, 12, 15: return "R9";
      13, 14:     return "R10";
      16:         return "R11";
      default:    return "R12";
    endcase
  endfunction

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // model: returns {result, status}
  function automatic logic [15:0] model(input logic [4:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] s);
    int ai, bi, ci, r, sr, hn;
    logic [7:0] res, o;
    bit wr;
    ai = int'(a); bi = int'(b); ci = int'(s[0]);
    o = s; res = a; wr = 1'b1;
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        r = ai + bi + ci; res = 8'(r);
        sr = sx(ai) + sx(bi) + ci; hn = (ai % 16) + (bi % 16) + ci;
        o[0] = (r > 255); o[5] = (hn > 15); o[3] = (sr > 127 || sr < -128);
        o[1] = (res == 0); o[2] = res[7];
      end
      2, 3, 8: begin
        if (op == 8) begin bi = ai; ai = 0; end
        if (op != 3) ci = 0;
        r = ai - bi - ci; res = 8'(r);
        sr = sx(ai) - sx(bi) - ci; hn = (ai % 16) - (bi % 16) - ci;
        o[0] = (r < 0); o[5] = (hn < 0); o[3] = (sr > 127 || sr < -128);
        o[2] = res[7];
        o[1] = (op == 3) ? ((res == 0) && s[1]) : (res == 0);
      end
      4, 5, 6: begin
        res = (op == 4) ? (a & b) : (op == 5) ? (a | b) : (a ^ b);
        o[3] = 1'b0; o[2] = res[7]; o[1] = (res == 0);
      end
      7: begin
        res = 8'(255 - ai);
        o[0] = 1'b1; o[3] = 1'b0; o[2] = res[7]; o[1] = (res == 0);
      end
      9, 10: begin
        res = (op == 9) ? 8'(ai + 1) : 8'(ai - 1);
        o[3] = (op == 9) ? (ai == 127) : (ai == 128);
        o[2] = res[7]; o[1] = (res == 0);
      end
      11, 12, 13, 14, 15: begin
        case (op)
          11: begin res = 8'(ai * 2);               o[0] = a[7]; end
          13: begin res = 8'(ai * 2 + ci);          o[0] = a[7]; end
          12: begin res = 8'(ai / 2);               o[0] = a[0]; end
          14: begin res = 8'(ai / 2 + ci * 128);    o[0] = a[0]; end
          default: begin res = 8'(ai / 2 + (a[7] ? 128 : 0)); o[0] = a[0]; end
        endcase
        o[2] = res[7]; o[1] = (res == 0); o[3] = o[2] ^ o[0];
      end
      16: begin res = {a[3:0], a[7:4]}; wr = 1'b0; end
      default: wr = 1'b0;
    endcase
    if (wr) o[4] = o[2] ^ o[3];
    return {res, o};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive out_ready, evaluate handshakes, advance to next negedge
  task automatic step(output bit accepted);
    out_ready = force_ready ? 1'b1 : (($urandom % 4) != 0);
    #1;
    if (held) chk("R2", {out_result, out_sreg}, held_val);
    held = 1'b0;
    if (out_valid && !out_ready) begin held = 1'b1; held_val = {out_result, out_sreg}; end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk("R1", 16'h0001, 16'h0000);
      else chk(tag(op_q[0]), {out_result, out_sreg}, exp_q[0]);
      if (exp_q.size() != 0) begin void'(exp_q.pop_front()); void'(op_q.pop_front()); end
    end
    chk("R1", {15'd0, in_ready}, {15'd0, (!out_valid || out_ready)});
    accepted = in_valid && in_ready;
    if (accepted) begin
      exp_q.push_back(model(in_op, in_a, in_b, in_sreg));
      op_q.push_back(in_op);
    end
    @(negedge clk);
  endtask

  task automatic send(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] s);
    bit acc;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_sreg = s;
    do step(acc); while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    bit acc;
    force_ready = 1'b1;
    for (int i = 0; i < 4; i++) step(acc);
    force_ready = 1'b0;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit acc;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {14'd0, out_valid, in_ready}, 16'h0001);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: one-cycle latency with an idle consumer ready
    force_ready = 1'b1;
    in_valid = 1'b1; in_op = 5'd0; in_a = 8'h12; in_b = 8'h34; in_sreg = 8'hC0;
    step(acc);
    in_valid = 1'b0;
    #1 chk("R1", {15'd0, out_valid}, 16'h0001);
    force_ready = 1'b0;
    drain();

    // directed corners
    send(5'd0,  8'h7F, 8'h01, 8'h00);  // R4 V and H
    send(5'd0,  8'hFF, 8'h01, 8'h00);  // R4 C, Z
    send(5'd1,  8'h0F, 8'h00, 8'h01);  // R4 carry in
    send(5'd2,  8'h00, 8'h01, 8'h00);  // R5 borrow
    send(5'd3,  8'h40, 8'h40, 8'h00);  // R5 Z sticky stays 0
    send(5'd3,  8'h40, 8'h40, 8'h02);  // R5 Z sticky stays 1
    send(5'd3,  8'h41, 8'h40, 8'h03);  // R5 borrow in gives zero
    send(5'd4,  8'hF0, 8'h0F, 8'h29);  // R6 AND zero, C/H kept
    send(5'd5,  8'h80, 8'h01, 8'h08);  // R6 OR, V cleared
    send(5'd7,  8'h00, 8'h55, 8'h20);  // R7 complement
    send(5'd8,  8'h80, 8'h00, 8'h00);  // R7 negate 0x80
    send(5'd8,  8'h00, 8'h00, 8'h01);  // R7 negate zero
    send(5'd9,  8'h7F, 8'h00, 8'h21);  // R8 increment overflow
    send(5'd10, 8'h80, 8'h00, 8'h01);  // R8 decrement overflow
    send(5'd11, 8'h80, 8'h00, 8'h00);  // R9 shift out to C
    send(5'd15, 8'h81, 8'h00, 8'h00);  // R9 arithmetic shift
    send(5'd14, 8'h01, 8'h00, 8'h01);  // R10 rotate right
    send(5'd13, 8'h80, 8'h00, 8'h01);  // R10 rotate left
    send(5'd16, 8'hA5, 8'h3C, 8'hFF);  // R11 swap
    send(5'd20, 8'h5A, 8'hFF, 8'h3C);  // R12 unused code
    drain();

    // random mix with back-pressure; in_valid held to overlap drain and load
    for (int i = 0; i < 600; i++) begin
      in_valid = ($urandom % 5) != 0;
      in_op = 5'($urandom % 20);
      in_a = 8'($urandom); in_b = 8'($urandom); in_sreg = 8'($urandom);
      step(acc);
    end
    in_valid = 1'b0;
    drain();
    chk("R1", {15'd0, out_valid}, 16'h0000);
    chk("R1", 16'(exp_q.size()), 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule